// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one memory burst request into a stream of column addresses, one per clock. A request carries a start column, a burst-length selection, a wrap-order selection and a full-page flag. From the clock after the request, the block presents one column per cycle together with a valid flag. A last flag marks the final beat of a fixed-length burst. Address bits above the burst-length boundary stay at the start column's value. The bits below it either count upward with wrap-around or are combined with the beat count by XOR.

In full-page mode the address walks sequentially across the whole page and wraps at the page size. The page size follows from the device data width: 2048 columns for a 4-bit device, 1024 for an 8-bit device and 512 for a 16-bit device. A full-page burst has no natural end. It stops only when a terminate pulse or a new request arrives. A new request is accepted on any clock and immediately replaces whatever burst is in flight, so a command stream can issue a random column every cycle.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and until the first request, `col_valid` and `col_last` are low.
- R2: In the cycle after a clock edge that samples `start` high, `col_out` equals the sampled `start_col` and `col_valid` is high.
- R3: With `full_page` low, `bl_sel` values 0, 1, 2 and 3 give bursts of exactly 1, 2, 4 and 8 valid beats. `col_valid` is low in the cycle after the last beat unless a new request arrived.
- R4: With `wrap_il` = 0 (sequential), beat k carries the start column's upper bits unchanged. Its low log2(BL) bits equal (start + k) mod BL.
- R5: With `wrap_il` = 1 (interleaved), beat k carries the start column's upper bits unchanged. Its low log2(BL) bits equal start XOR k.
- R6: With `full_page` high, beat k is (start + k) mod 2^COL_W, and `wrap_il` is ignored. The burst continues past the page end until it is ended by `stop` or a new request.
- R7: `col_last` is high only on the final beat of a fixed-length burst. It is never high during a full-page burst or while `col_valid` is low.
- R8: A request during a running burst restarts the sequence from the new column in the next cycle. When `start` and `stop` are both high, `start` wins.
- R9: `stop` sampled high during a burst, with `start` low, makes `col_valid` low in the next cycle. `stop` while idle leaves `col_valid` low.
- R10: `bl_sel`, `wrap_il`, `full_page` and `start_col` are captured only when a request is accepted. Changing them during a burst does not alter its addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | New burst request, starts or restarts a burst |
| start_col | input | COL_W | First column of the burst |
| bl_sel | input | 2 | Burst length: 0=1, 1=2, 2=4, 3=8 beats |
| wrap_il | input | 1 | 0 sequential order, 1 interleaved order |
| full_page | input | 1 | 1 selects a full-page burst, overriding bl_sel and wrap_il |
| stop | input | 1 | Terminates the running burst |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | `col_out` carries a burst beat |
| col_last | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The first beat of a burst is due one clock after the edge that samples the request. Each further beat follows one clock later. `col_valid` drops one clock after the final beat, or one clock after a sampled `stop`. The bench drives every input on falling edges and compares the outputs on the next falling edge. Beat k is therefore checked exactly k+1 falling edges after the request was driven, and the idle check falls on the edge after the last beat. The sweep covers every length, both orders and many start columns. Configuration inputs are scrambled right after each request, to confirm that the block captured them at the request.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

   typedef enum logic [1:0] {
      BL_ONE   = 2'd0,
      BL_TWO   = 2'd1,
      BL_FOUR  = 2'd2,
      BL_EIGHT = 2'd3
   } bl_sel_e;

   // Page column-address width for a given device data width.
   function automatic int page_col_bits(input int org_width);
      case (org_width)
         4:       return 11;
         8:       return 10;
         16:      return 9;
         default: return 0;
      endcase
   endfunction

   // Beats minus one for a fixed burst selection.
   function automatic logic [3:0] fixed_len_m1(input logic [1:0] sel);
      return 4'((5'd1 << sel) - 5'd1);
   endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_col_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic [1:0]       bl_sel,
   input  logic             full_page,
   input  logic             wrap_il,
   output logic [COL_W-1:0] len_m1,
   output logic             eff_il
);

   if (COL_W < 4) begin : g_bad_width
      $error("burst_len_decode: COL_W must be at least 4");
   end

   always_comb begin
      if (full_page) begin
         len_m1 = '1;
         eff_il = 1'b0;
      end else begin
         len_m1 = COL_W'(fixed_len_m1(bl_sel));
         eff_il = wrap_il;
      end
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic [COL_W-1:0] len_m1_in,
   input  logic             full_in,
   output logic [COL_W-1:0] cnt,
   output logic [COL_W-1:0] len_q,
   output logic             active,
   output logic             last
);

   logic full_q;
   logic at_end;

   assign at_end = !full_q && (cnt == len_q);
   assign last   = active && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         len_q  <= '0;
         full_q <= 1'b0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= '0;
         len_q  <= len_m1_in;
         full_q <= full_in;
      end else if (active) begin
         if (stop || at_end) begin
            active <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
   parameter int COL_W = 9
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] cnt,
   input  logic [COL_W-1:0] mask,
   input  logic             il,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] sum;

   // Carries into a masked bit come only from lower masked bits,
   // so the low field wraps modulo the burst length.
   assign sum = base + cnt;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      assign col[i] = mask[i] ? (il ? (base[i] ^ cnt[i]) : sum[i]) : base[i];
   end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import burst_col_pkg::*;
#(
   parameter int ORG_WIDTH = 16,
   localparam int COL_W = page_col_bits(ORG_WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic [1:0]       bl_sel,
   input  logic             wrap_il,
   input  logic             full_page,
   input  logic             stop,
   output logic [COL_W-1:0] col_out,
   output logic             col_valid,
   output logic             col_last
);

   if (COL_W == 0) begin : g_bad_org
      $error("burst_col_gen: ORG_WIDTH must be 4, 8 or 16");
   end

   logic [COL_W-1:0] len_m1_d;
   logic             il_d;
   logic [COL_W-1:0] cnt;
   logic [COL_W-1:0] len_q;
   logic [COL_W-1:0] base_q;
   logic             il_q;

   burst_len_decode #(.COL_W(COL_W)) u_dec (
      .bl_sel    (bl_sel),
      .full_page (full_page),
      .wrap_il   (wrap_il),
      .len_m1    (len_m1_d),
      .eff_il    (il_d)
   );

   burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .stop      (stop),
      .len_m1_in (len_m1_d),
      .full_in   (full_page),
      .cnt       (cnt),
      .len_q     (len_q),
      .active    (col_valid),
      .last      (col_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         il_q   <= 1'b0;
      end else if (start) begin
         base_q <= start_col;
         il_q   <= il_d;
      end
   end

   burst_addr_map #(.COL_W(COL_W)) u_map (
      .base (base_q),
      .cnt  (cnt),
      .mask (len_q),
      .il   (il_q),
      .col  (col_out)
   );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             stop,
   input logic [COL_W-1:0] start_col,
   input logic [COL_W-1:0] col_out,
   input logic             col_valid,
   input logic             col_last
);

   // R2
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (col_valid && col_out == $past(start_col)));

   // R7
   last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_last |-> col_valid);

   // R3
   end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_last && !start) |=> !col_valid);

   // R9
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && stop && !start) |=> !col_valid);

   // R1
   idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!col_valid && !start) |=> !col_valid);

   // R6
   keeps_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && !col_last && !stop && !start) |=> col_valid);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;

   localparam int W = 9;
   localparam int PAGE = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] start_col = '0;
   logic [1:0]   bl_sel = '0;
   logic         wrap_il = 1'b0;
   logic         full_page = 1'b0;
   logic         stop = 1'b0;
   logic [W-1:0] col_out;
   logic         col_valid;
   logic         col_last;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   burst_col_gen #(.ORG_WIDTH(16)) dut (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic request(input logic [W-1:0] c, input logic [1:0] s,
                          input logic il, input logic fp);
      start = 1'b1; start_col = c; bl_sel = s; wrap_il = il; full_page = fp;
      @(negedge clk);
      start = 1'b0; start_col = ~c; bl_sel = ~s; wrap_il = ~il; full_page = ~fp; // R10 scramble
   endtask

   task automatic run_fixed(input logic [W-1:0] c, input logic [1:0] s, input logic il);
      int n;
      logic [W-1:0] m, e;
      n = 1 << s;
      m = W'(n - 1);
      request(c, s, il, 1'b0);
      for (int k = 0; k < n; k++) begin
         if (il) e = (c & ~m) | ((c ^ W'(k)) & m);   // R5
         else    e = (c & ~m) | ((c + W'(k)) & m);   // R4
         check(col_out == e, il ? "R5 interleaved col" : "R4 sequential col", int'(col_out), int'(e));
         check(col_valid == 1'b1, "R3 valid in burst", int'(col_valid), 1);
         check(col_last == (k == n - 1), "R7 last flag", int'(col_last), int'(k == n - 1));
         @(negedge clk);
      end
      check(col_valid == 1'b0, "R3 burst length end", int'(col_valid), 0);
      full_page = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check(col_valid == 1'b0, "R1 reset valid", int'(col_valid), 0);
      check(col_last == 1'b0, "R1 reset last", int'(col_last), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(col_valid == 1'b0, "R1 idle after reset", int'(col_valid), 0);

      // R9 stop while idle
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check(col_valid == 1'b0, "R9 idle stop", int'(col_valid), 0);

      // R2 R3 R4 R5 R7 R10 sweep
      for (int s = 0; s < 4; s++)
         for (int il = 0; il < 2; il++) begin
            for (int c = 0; c < 16; c++)
               run_fixed(W'(c), 2'(s), 1'(il));
            run_fixed(W'(PAGE - 3), 2'(s), 1'(il));
            run_fixed(W'(9'h0AD), 2'(s), 1'(il));
         end

      // R6 full page: wrap past page end, interleave ignored, never last
      request(W'(PAGE - 5), 2'd0, 1'b1, 1'b1);
      for (int k = 0; k < 40; k++) begin
         check(col_out == W'(PAGE - 5 + k), "R6 full page col", int'(col_out), (PAGE - 5 + k) % PAGE);
         check(col_valid && !col_last, "R6 full page running", int'({col_valid, col_last}), 2);
         @(negedge clk);
      end
      // R9 stop ends full page
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check(col_valid == 1'b0, "R9 stop ends burst", int'(col_valid), 0);

      // R8 interrupt a running burst, start overriding stop
      request(W'(3), 2'd3, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) begin
         check(col_out == W'(3 + k), "R8 first burst col", int'(col_out), 3 + k);
         if (k < 2) @(negedge clk);
      end
      stop = 1'b1;
      request(W'(22), 2'd2, 1'b1, 1'b0);
      stop = 1'b0;
      for (int k = 0; k < 4; k++) begin
         check(col_out == W'(22 ^ k), "R8 restarted col", int'(col_out), 22 ^ k);
         check(col_last == (k == 3), "R8 restarted last", int'(col_last), int'(k == 3));
         @(negedge clk);
      end
      check(col_valid == 1'b0, "R8 restarted end", int'(col_valid), 0);

      // R2 back-to-back single beats, a new column every clock
      start = 1'b1; bl_sel = 2'd0; full_page = 1'b0; wrap_il = 1'b0;
      for (int k = 0; k < 6; k++) begin
         start_col = W'(100 + 7 * k);
         @(negedge clk);
         check(col_out == W'(100 + 7 * k) && col_valid && col_last,
               "R2 every-clock column", int'(col_out), 100 + 7 * k);
      end
      start = 1'b0;
      @(negedge clk);
      check(col_valid == 1'b0, "R3 single beat end", int'(col_valid), 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule